// File: doc/BRIEF.md
# Snooping Three-State Coherence Controller

This block keeps one direct-mapped, write-back data cache coherent with its peers on a shared snooping bus. Each line holds one data word, a tag and a coherence state: invalid, shared (clean, possibly held elsewhere) or exclusive (dirty, held only here). The local processor sends read, write and evict requests. The controller answers hits itself. It turns misses, upgrades and dirty evictions into bus transactions: a bus read to fetch a line, a bus write that invalidates every other copy, and a write-back of dirty data to memory. All of these are issued one at a time over a valid/ready handshake.

The snoop side watches transactions that other caches place on the bus. Every controller sees these in the same global order. When another cache reads a line held here as exclusive, this cache drives the dirty word out in the same cycle so that memory and the reader receive current data, and the line drops to shared. When another cache writes a line held here, the local copy becomes invalid. A write that follows a snooped read of the same address therefore returns the new value to the next reader, and memory ends up holding that value too.

Top module: `snoop_coherence_ctrl`

## Requirements
- R1: After reset, every line is invalid, `cpu_req_ready` is 1, and `bus_req_valid`, `cpu_resp_valid` and `snoop_flush` are 0.
- R2: A read (op 0) whose tag matches a non-invalid line responds with hit 1 and the stored word, and issues no bus transaction.
- R3: A read miss issues one bus read (cmd 1) for the requested address, fills the line as shared with `bus_rsp_data`, and returns that word with hit 0.
- R4: A write (op 1) to a shared line issues one bus write (cmd 2) and leaves the line exclusive with the new word. A write to an exclusive line updates it with no bus transaction. Both respond with hit 1.
- R5: A write miss issues one bus write (cmd 2) and installs the line as exclusive with the written word. The response has hit 0.
- R6: On a miss whose victim line is exclusive, a write-back (cmd 3) carrying the victim's address and word comes first, followed by the bus read or bus write for the request. A shared victim is dropped with no bus traffic.
- R7: An evict (op 2) of an exclusive line writes it back (cmd 3) and invalidates it. An evict of a shared line invalidates it with no bus traffic. Both respond with hit 1. An evict of an absent address responds with hit 0 and does nothing.
- R8: A snooped bus read (cmd 1) of an exclusive line raises `snoop_flush` in the same cycle, drives the line's word on `snoop_flush_data`, and leaves the line shared. A snooped read of a shared line, or of a non-matching tag, causes no flush and no state change.
- R9: A snooped bus write (cmd 2) that matches a shared or exclusive line makes it invalid. A snooped write-back (cmd 3) is ignored.
- R10: While `bus_req_valid` is 1 and `bus_req_ready` is 0, the command, address and data stay stable. Only one transaction is outstanding, and `cpu_req_ready` is 0 while the controller is busy.
- R11: `cpu_resp_valid` is a one-cycle pulse. It comes in the cycle after acceptance for requests served without the bus, and in the cycle after the last bus handshake otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_req_ready | output | 1 | Controller idle and accepting |
| cpu_resp_valid | output | 1 | Response pulse |
| cpu_resp_hit | output | 1 | Tag was present in a valid state |
| cpu_resp_rdata | output | DATA_W | Read data, or written word for writes |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 1 bus read, 2 bus write (invalidate), 3 write-back |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_data | output | DATA_W | Write-back or write word |
| bus_req_ready | input | 1 | Bus accepts/completes the transaction |
| bus_rsp_data | input | DATA_W | Fill word, valid with ready on a bus read |
| snoop_valid | input | 1 | Another cache's transaction is visible |
| snoop_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_flush | output | 1 | Dirty copy supplied for a snooped read |
| snoop_flush_data | output | DATA_W | Supplied word |

## Verification
The assertions assume that the bus is globally ordered. A snooped transaction never lands in the same cycle as this controller's own bus handshake, and `bus_req_ready` is only raised while a request is pending. The bench drives snoops only between processor requests. Its bus model raises ready for one cycle after an optional wait and never while the request is idle. Under that ordering, the checks on the line state after a snoop can ignore any same-cycle update from the processor side.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_EVICT = 2'd2
    } cpu_op_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_WR   = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_VWB,
        PS_FILL,
        PS_UPG,
        PS_EWB
    } pstate_e;

    function automatic logic st_valid(line_st_e s);
        return s != ST_INV;
    endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  p_idx,
    output logic [TAG_W-1:0]  p_tag,
    output line_st_e          p_st,
    output logic [DATA_W-1:0] p_data,
    input  logic              p_we,
    input  logic [TAG_W-1:0]  p_wr_tag,
    input  line_st_e          p_wr_st,
    input  logic              p_wr_den,
    input  logic [DATA_W-1:0] p_wr_data,
    input  logic [IDX_W-1:0]  s_idx,
    output logic [TAG_W-1:0]  s_tag,
    output line_st_e          s_st,
    output logic [DATA_W-1:0] s_data,
    input  logic              s_we,
    input  line_st_e          s_wr_st,
    output line_st_e          st_all [LINES]
);

    logic [TAG_W-1:0]  tag_q  [LINES];
    line_st_e          st_q   [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i]   <= ST_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (p_we && p_idx == IDX_W'(i)) begin
                st_q[i]  <= p_wr_st;
                tag_q[i] <= p_wr_tag;
                if (p_wr_den) data_q[i] <= p_wr_data;
            end else if (s_we && s_idx == IDX_W'(i)) begin
                st_q[i] <= s_wr_st;
            end
        end
        assign st_all[i] = st_q[i];
    end

    assign p_tag  = tag_q[p_idx];
    assign p_st   = st_q[p_idx];
    assign p_data = data_q[p_idx];
    assign s_tag  = tag_q[s_idx];
    assign s_st   = st_q[s_idx];
    assign s_data = data_q[s_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              snoop_valid,
    input  bus_cmd_e          snoop_cmd,
    input  logic [TAG_W-1:0]  snoop_tag,
    input  logic [TAG_W-1:0]  line_tag,
    input  line_st_e          line_st,
    input  logic [DATA_W-1:0] line_data,
    output logic              flush,
    output logic [DATA_W-1:0] flush_data,
    output logic              s_we,
    output line_st_e          s_wr_st
);

    logic match;
    assign match = snoop_valid && st_valid(line_st) && (line_tag == snoop_tag);

    always_comb begin
        flush      = 1'b0;
        flush_data = '0;
        s_we       = 1'b0;
        s_wr_st    = line_st;
        case (snoop_cmd)
            BC_RD: if (match && line_st == ST_EXC) begin
                flush      = 1'b1;
                flush_data = line_data;
                s_we       = 1'b1;
                s_wr_st    = ST_SHR;
            end
            BC_WR: if (match) begin
                s_we    = 1'b1;
                s_wr_st = ST_INV;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/coh_proc_fsm.sv
module coh_proc_fsm
    import coh_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic [1:0]        cpu_req_op,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              bus_req_valid,
    output bus_cmd_e          bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_req_ready,
    input  logic [DATA_W-1:0] bus_rsp_data,
    output logic [IDX_W-1:0]  look_idx,
    input  logic [TAG_W-1:0]  l_tag,
    input  line_st_e          l_st,
    input  logic [DATA_W-1:0] l_data,
    output logic              p_we,
    output logic [TAG_W-1:0]  p_wr_tag,
    output line_st_e          p_wr_st,
    output logic              p_wr_den,
    output logic [DATA_W-1:0] p_wr_data
);

    pstate_e           ps_q, ps_d;
    cpu_op_e           op_q;
    logic [ADDR_W-1:0] addr_q, vaddr_q;
    logic [DATA_W-1:0] wdata_q, vdata_q;
    logic              hit_q;

    logic [ADDR_W-1:0] look_addr;
    logic [TAG_W-1:0]  look_tag;
    logic              tag_hit;
    cpu_op_e           op_in;

    logic              cap, cap_victim, hit_d;
    logic              rsp_set, rsp_hit_d;
    logic [DATA_W-1:0] rsp_data_d;

    assign op_in     = cpu_op_e'(cpu_req_op);
    assign look_addr = (ps_q == PS_IDLE) ? cpu_req_addr : addr_q;
    assign look_idx  = look_addr[IDX_W-1:0];
    assign look_tag  = look_addr[ADDR_W-1:IDX_W];
    assign tag_hit   = st_valid(l_st) && (l_tag == look_tag);

    always_comb begin
        ps_d       = ps_q;
        p_we       = 1'b0;
        p_wr_tag   = look_tag;
        p_wr_st    = ST_INV;
        p_wr_den   = 1'b0;
        p_wr_data  = '0;
        cap        = 1'b0;
        cap_victim = 1'b0;
        hit_d      = 1'b0;
        rsp_set    = 1'b0;
        rsp_hit_d  = 1'b0;
        rsp_data_d = '0;
        case (ps_q)
            PS_IDLE: if (cpu_req_valid) begin
                cap   = 1'b1;
                hit_d = tag_hit;
                case (op_in)
                    OP_RD: begin
                        if (tag_hit) begin
                            rsp_set    = 1'b1;
                            rsp_hit_d  = 1'b1;
                            rsp_data_d = l_data;
                        end else if (l_st == ST_EXC) begin
                            ps_d       = PS_VWB;
                            cap_victim = 1'b1;
                        end else begin
                            ps_d = PS_FILL;
                        end
                    end
                    OP_WR: begin
                        if (tag_hit && l_st == ST_EXC) begin
                            p_we       = 1'b1;
                            p_wr_st    = ST_EXC;
                            p_wr_den   = 1'b1;
                            p_wr_data  = cpu_req_wdata;
                            rsp_set    = 1'b1;
                            rsp_hit_d  = 1'b1;
                            rsp_data_d = cpu_req_wdata;
                        end else if (!tag_hit && l_st == ST_EXC) begin
                            ps_d       = PS_VWB;
                            cap_victim = 1'b1;
                        end else begin
                            ps_d = PS_UPG;
                        end
                    end
                    OP_EVICT: begin
                        if (tag_hit && l_st == ST_EXC) begin
                            ps_d       = PS_EWB;
                            cap_victim = 1'b1;
                        end else if (tag_hit) begin
                            p_we      = 1'b1;
                            p_wr_st   = ST_INV;
                            rsp_set   = 1'b1;
                            rsp_hit_d = 1'b1;
                        end else begin
                            rsp_set = 1'b1;
                        end
                    end
                    default: rsp_set = 1'b1;
                endcase
            end
            PS_VWB: if (bus_req_ready) begin
                ps_d = (op_q == OP_RD) ? PS_FILL : PS_UPG;
            end
            PS_FILL: if (bus_req_ready) begin
                p_we       = 1'b1;
                p_wr_st    = ST_SHR;
                p_wr_den   = 1'b1;
                p_wr_data  = bus_rsp_data;
                rsp_set    = 1'b1;
                rsp_hit_d  = hit_q;
                rsp_data_d = bus_rsp_data;
                ps_d       = PS_IDLE;
            end
            PS_UPG: if (bus_req_ready) begin
                p_we       = 1'b1;
                p_wr_st    = ST_EXC;
                p_wr_den   = 1'b1;
                p_wr_data  = wdata_q;
                rsp_set    = 1'b1;
                rsp_hit_d  = hit_q;
                rsp_data_d = wdata_q;
                ps_d       = PS_IDLE;
            end
            PS_EWB: if (bus_req_ready) begin
                p_we      = 1'b1;
                p_wr_st   = ST_INV;
                rsp_set   = 1'b1;
                rsp_hit_d = 1'b1;
                ps_d      = PS_IDLE;
            end
            default: ps_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q       <= PS_IDLE;
            op_q       <= OP_RD;
            addr_q     <= '0;
            wdata_q    <= '0;
            vaddr_q    <= '0;
            vdata_q    <= '0;
            hit_q      <= 1'b0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_rdata <= '0;
        end else begin
            ps_q       <= ps_d;
            resp_valid <= rsp_set;
            if (rsp_set) begin
                resp_hit   <= rsp_hit_d;
                resp_rdata <= rsp_data_d;
            end
            if (cap) begin
                op_q    <= op_in;
                addr_q  <= cpu_req_addr;
                wdata_q <= cpu_req_wdata;
                hit_q   <= hit_d;
            end
            if (cap_victim) begin
                vaddr_q <= {l_tag, look_idx};
                vdata_q <= l_data;
            end
        end
    end

    always_comb begin
        bus_req_valid = (ps_q != PS_IDLE);
        bus_req_cmd   = BC_NONE;
        bus_req_addr  = addr_q;
        bus_req_data  = '0;
        case (ps_q)
            PS_VWB, PS_EWB: begin
                bus_req_cmd  = BC_WB;
                bus_req_addr = vaddr_q;
                bus_req_data = vdata_q;
            end
            PS_FILL: bus_req_cmd = BC_RD;
            PS_UPG: begin
                bus_req_cmd  = BC_WR;
                bus_req_data = wdata_q;
            end
            default: ;
        endcase
    end

    assign cpu_req_ready = (ps_q == PS_IDLE);

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> cpu_req_ready && !bus_req_valid && !resp_valid);

    assert_silent_excl_write_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_req_ready && cpu_req_valid && cpu_req_op == 2'd1 && l_st == ST_EXC
        && l_tag == cpu_req_addr[ADDR_W-1:IDX_W] |=> !bus_req_valid && resp_valid);

    assert_refill_after_wb_R6: assert property (@(posedge clk) disable iff (rst)
        ps_q == PS_VWB && bus_req_ready |=> bus_req_valid && bus_req_cmd != BC_WB
        && bus_req_addr == addr_q);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_cmd)
        && $stable(bus_req_addr) && $stable(bus_req_data));

    assert_busy_blocks_cpu_R10: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> !cpu_req_ready);

    assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

endmodule

// File: rtl/snoop_coherence_ctrl.sv
module snoop_coherence_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic [1:0]        cpu_req_op,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic              cpu_resp_hit,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_req_ready,
    input  logic [DATA_W-1:0] bus_rsp_data,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_flush,
    output logic [DATA_W-1:0] snoop_flush_data
);

    logic [IDX_W-1:0]  look_idx, s_idx;
    logic [TAG_W-1:0]  l_tag, s_tag, p_wr_tag, snp_tag;
    line_st_e          l_st, s_st, p_wr_st, s_wr_st;
    logic [DATA_W-1:0] l_data, s_data, p_wr_data;
    logic              p_we, p_wr_den, s_we;
    bus_cmd_e          cmd_out;
    line_st_e          st_all [LINES];

    assign s_idx       = snoop_addr[IDX_W-1:0];
    assign snp_tag     = snoop_addr[ADDR_W-1:IDX_W];
    assign bus_req_cmd = cmd_out;

    coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst),
        .p_idx(look_idx), .p_tag(l_tag), .p_st(l_st), .p_data(l_data),
        .p_we(p_we), .p_wr_tag(p_wr_tag), .p_wr_st(p_wr_st),
        .p_wr_den(p_wr_den), .p_wr_data(p_wr_data),
        .s_idx(s_idx), .s_tag(s_tag), .s_st(s_st), .s_data(s_data),
        .s_we(s_we), .s_wr_st(s_wr_st), .st_all(st_all)
    );

    coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snoop_valid(snoop_valid), .snoop_cmd(bus_cmd_e'(snoop_cmd)),
        .snoop_tag(snp_tag), .line_tag(s_tag), .line_st(s_st), .line_data(s_data),
        .flush(snoop_flush), .flush_data(snoop_flush_data),
        .s_we(s_we), .s_wr_st(s_wr_st)
    );

    coh_proc_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready),
        .resp_valid(cpu_resp_valid), .resp_hit(cpu_resp_hit), .resp_rdata(cpu_resp_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(cmd_out),
        .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
        .bus_req_ready(bus_req_ready), .bus_rsp_data(bus_rsp_data),
        .look_idx(look_idx), .l_tag(l_tag), .l_st(l_st), .l_data(l_data),
        .p_we(p_we), .p_wr_tag(p_wr_tag), .p_wr_st(p_wr_st),
        .p_wr_den(p_wr_den), .p_wr_data(p_wr_data)
    );

    assert_flush_downgrades_R8: assert property (@(posedge clk) disable iff (rst)
        snoop_flush && !p_we |=> st_all[$past(s_idx)] == ST_SHR);

    assert_snoop_write_kills_R9: assert property (@(posedge clk) disable iff (rst)
        snoop_valid && snoop_cmd == 2'd2 && s_st != ST_INV && s_tag == snp_tag && !p_we
        |=> st_all[$past(s_idx)] == ST_INV);

    assert_flush_only_on_read_R8: assert property (@(posedge clk) disable iff (rst)
        snoop_flush |-> snoop_valid && snoop_cmd == 2'd1);

endmodule

// File: tb/tb_snoop_coherence_ctrl.sv
module tb_snoop_coherence_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req_valid = 1'b0;
    logic [1:0]    cpu_req_op = 2'd0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_req_ready, cpu_resp_valid, cpu_resp_hit;
    logic [DW-1:0] cpu_resp_rdata;
    logic          bus_req_valid;
    logic [1:0]    bus_req_cmd;
    logic [AW-1:0] bus_req_addr;
    logic [DW-1:0] bus_req_data;
    logic          bus_req_ready = 1'b0;
    logic [DW-1:0] bus_rsp_data = '0;
    logic          snoop_valid = 1'b0;
    logic [1:0]    snoop_cmd = 2'd0;
    logic [AW-1:0] snoop_addr = '0;
    logic          snoop_flush;
    logic [DW-1:0] snoop_flush_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_coherence_ctrl dut (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_hit(cpu_resp_hit), .cpu_resp_rdata(cpu_resp_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
        .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
        .bus_req_ready(bus_req_ready), .bus_rsp_data(bus_rsp_data),
        .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
        .snoop_flush(snoop_flush), .snoop_flush_data(snoop_flush_data)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory and bus responder
    logic [DW-1:0] mem [256];
    int            bus_delay = 0;
    int            wait_cnt = 0;
    int            n_tx = 0;
    logic [3:0]    seq_log = '0;
    logic [1:0]    held_cmd;
    logic [AW-1:0] held_addr;
    logic [DW-1:0] held_data;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 | i;
    end

    initial begin
        forever begin
            @(negedge clk);
            if (bus_req_ready) begin
                bus_req_ready = 1'b0;
            end else if (bus_req_valid) begin
                if (wait_cnt > 0) begin
                    // R10: request stable while waiting
                    chk(bus_req_cmd == held_cmd && bus_req_addr == held_addr
                        && bus_req_data == held_data, 10, "request held",
                        {bus_req_cmd, bus_req_addr, 18'd0}, {held_cmd, held_addr, 18'd0});
                    chk(!cpu_req_ready, 10, "cpu ready while busy",
                        {31'd0, cpu_req_ready}, 32'd0);
                end
                held_cmd  = bus_req_cmd;
                held_addr = bus_req_addr;
                held_data = bus_req_data;
                if (wait_cnt < bus_delay) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    bus_req_ready = 1'b1;
                    bus_rsp_data = mem[bus_req_addr[7:0]];
                    if (bus_req_cmd == 2'd3) mem[bus_req_addr[7:0]] = bus_req_data;
                    if (n_tx == 0) seq_log[3:2] = bus_req_cmd;
                    else if (n_tx == 1) seq_log[1:0] = bus_req_cmd;
                    n_tx++;
                end
            end
        end
    end

    task automatic do_cpu(input logic [1:0] op, input logic [AW-1:0] addr,
                          input logic [DW-1:0] wd, output logic hit,
                          output logic [DW-1:0] rd, output int lat);
        @(negedge clk);
        n_tx = 0;
        seq_log = '0;
        cpu_req_valid = 1'b1;
        cpu_req_op = op;
        cpu_req_addr = addr;
        cpu_req_wdata = wd;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 0;
        while (!cpu_resp_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        hit = cpu_resp_hit;
        rd = cpu_resp_rdata;
        @(negedge clk);
        // R11: response lasts one cycle
        chk(!cpu_resp_valid, 11, "response pulse width", {31'd0, cpu_resp_valid}, 32'd0);
    endtask

    task automatic do_snoop(input logic [1:0] cmd, input logic [AW-1:0] addr,
                            output logic fl, output logic [DW-1:0] fd);
        @(negedge clk);
        snoop_valid = 1'b1;
        snoop_cmd = cmd;
        snoop_addr = addr;
        #1;
        fl = snoop_flush;
        fd = snoop_flush_data;
        if (fl) mem[addr[7:0]] = fd;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    typedef struct packed {
        logic          snp;
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic          ehit;
        logic [DW-1:0] edata;
        logic [3:0]    eseq;
        logic [3:0]    req;
    } vec_t;

    // op: cpu 0 rd 1 wr 2 evict; snoop 1 rd 2 wr 3 wb. seq = {first cmd, second cmd}
    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 12'h010, 32'h0,        1'b0, 32'hA000_0010, 4'h4, 4'd3},  // R3
        '{1'b0, 2'd0, 12'h010, 32'h0,        1'b1, 32'hA000_0010, 4'h0, 4'd2},  // R2
        '{1'b0, 2'd1, 12'h010, 32'h1111_1111, 1'b1, 32'h1111_1111, 4'h8, 4'd4}, // R4
        '{1'b0, 2'd1, 12'h010, 32'h2222_2222, 1'b1, 32'h2222_2222, 4'h0, 4'd4}, // R4
        '{1'b1, 2'd1, 12'h010, 32'h0,        1'b1, 32'h2222_2222, 4'h0, 4'd8},  // R8
        '{1'b0, 2'd0, 12'h010, 32'h0,        1'b1, 32'h2222_2222, 4'h0, 4'd8},  // R8
        '{1'b1, 2'd1, 12'h010, 32'h0,        1'b0, 32'h0,         4'h0, 4'd8},  // R8
        '{1'b1, 2'd2, 12'h010, 32'h0,        1'b0, 32'h0,         4'h0, 4'd9},  // R9
        '{1'b0, 2'd0, 12'h010, 32'h0,        1'b0, 32'h2222_2222, 4'h4, 4'd9},  // R9
        '{1'b0, 2'd1, 12'h021, 32'h3333_3333, 1'b0, 32'h3333_3333, 4'h8, 4'd5}, // R5
        '{1'b0, 2'd0, 12'h031, 32'h0,        1'b0, 32'hA000_0031, 4'hD, 4'd6},  // R6
        '{1'b0, 2'd0, 12'h021, 32'h0,        1'b0, 32'h3333_3333, 4'h4, 4'd6},  // R6
        '{1'b0, 2'd2, 12'h021, 32'h0,        1'b1, 32'h0,         4'h0, 4'd7},  // R7
        '{1'b0, 2'd0, 12'h021, 32'h0,        1'b0, 32'h3333_3333, 4'h4, 4'd7},  // R7
        '{1'b0, 2'd1, 12'h002, 32'h4444_4444, 1'b0, 32'h4444_4444, 4'h8, 4'd5}, // R5
        '{1'b0, 2'd2, 12'h002, 32'h0,        1'b1, 32'h0,         4'hC, 4'd7},  // R7
        '{1'b0, 2'd0, 12'h002, 32'h0,        1'b0, 32'h4444_4444, 4'h4, 4'd7},  // R7
        '{1'b0, 2'd2, 12'h003, 32'h0,        1'b0, 32'h0,         4'h0, 4'd7},  // R7
        '{1'b1, 2'd1, 12'h050, 32'h0,        1'b0, 32'h0,         4'h0, 4'd8},  // R8
        '{1'b1, 2'd3, 12'h010, 32'h0,        1'b0, 32'h0,         4'h0, 4'd9},  // R9
        '{1'b0, 2'd0, 12'h010, 32'h0,        1'b1, 32'h2222_2222, 4'h0, 4'd9},  // R9
        '{1'b1, 2'd2, 12'h002, 32'h0,        1'b0, 32'h0,         4'h0, 4'd9},  // R9
        '{1'b0, 2'd0, 12'h002, 32'h0,        1'b0, 32'h4444_4444, 4'h4, 4'd9},  // R9
        '{1'b0, 2'd1, 12'h013, 32'h5555_5555, 1'b0, 32'h5555_5555, 4'h8, 4'd5}, // R5
        '{1'b1, 2'd2, 12'h013, 32'h0,        1'b0, 32'h0,         4'h0, 4'd9},  // R9
        '{1'b0, 2'd0, 12'h013, 32'h0,        1'b0, 32'hA000_0013, 4'h4, 4'd9},  // R9
        '{1'b0, 2'd1, 12'h010, 32'h6666_6666, 1'b1, 32'h6666_6666, 4'h8, 4'd4}, // R4
        '{1'b0, 2'd1, 12'h050, 32'h7777_7777, 1'b0, 32'h7777_7777, 4'hE, 4'd6}, // R6
        '{1'b0, 2'd0, 12'h010, 32'h0,        1'b0, 32'h6666_6666, 4'hD, 4'd6}   // R6
    };

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic          hit, fl;
        logic [DW-1:0] rd, fd;
        int            lat;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk(cpu_req_ready && !bus_req_valid && !cpu_resp_valid && !snoop_flush, 1,
            "reset outputs", {28'd0, cpu_req_ready, bus_req_valid, cpu_resp_valid, snoop_flush},
            32'h8);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v].snp) begin
                do_snoop(VEC[v].op, VEC[v].addr, fl, fd);
                chk(fl == VEC[v].ehit, VEC[v].req, $sformatf("vec %0d flush", v),
                    {31'd0, fl}, {31'd0, VEC[v].ehit});
                if (VEC[v].ehit)
                    chk(fd == VEC[v].edata, VEC[v].req, $sformatf("vec %0d flush data", v),
                        fd, VEC[v].edata);
            end else begin
                do_cpu(VEC[v].op, VEC[v].addr, VEC[v].wd, hit, rd, lat);
                chk(hit == VEC[v].ehit, VEC[v].req, $sformatf("vec %0d hit", v),
                    {31'd0, hit}, {31'd0, VEC[v].ehit});
                chk(rd == VEC[v].edata, VEC[v].req, $sformatf("vec %0d data", v),
                    rd, VEC[v].edata);
                chk(seq_log == VEC[v].eseq && n_tx == ((VEC[v].eseq[3:2] != 0) ? 1 : 0)
                    + ((VEC[v].eseq[1:0] != 0) ? 1 : 0), VEC[v].req,
                    $sformatf("vec %0d bus sequence", v),
                    {28'd0, seq_log}, {28'd0, VEC[v].eseq});
                if (VEC[v].eseq == 4'h0)
                    // R11: no-bus requests answer in the cycle after acceptance
                    chk(lat == 0, 11, $sformatf("vec %0d hit latency", v), lat, 0);
            end
        end

        // R10: slow bus, request must hold steady
        bus_delay = 3;
        do_cpu(2'd0, 12'h0A1, 32'h0, hit, rd, lat);
        chk(rd == 32'hA000_00A1 && !hit, 10, "slow bus read data", rd, 32'hA000_00A1);
        chk(seq_log == 4'h4, 10, "slow bus sequence", {28'd0, seq_log}, 32'h4);
        bus_delay = 0;

        // R1: reset in mid-life invalidates all lines
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_req_ready && !bus_req_valid && !cpu_resp_valid, 1, "second reset outputs",
            {29'd0, cpu_req_ready, bus_req_valid, cpu_resp_valid}, 32'h4);
        do_cpu(2'd0, 12'h0A1, 32'h0, hit, rd, lat);
        chk(!hit && seq_log == 4'h4, 1, "line invalid after reset",
            {27'd0, hit, seq_log}, 32'h4);
        do_snoop(2'd1, 12'h050, fl, fd);
        chk(!fl, 1, "no dirty line after reset", {31'd0, fl}, 32'd0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule